// File: doc/BRIEF.md
# Switching lattice connectivity evaluator

The block takes a rectangular grid of four-terminal switches, one control bit per site, and decides by iterative flood fill whether conducting sites form a chain between the top and bottom plates. A set bit makes a site conduct, and all four of its sides are then joined. A clear bit isolates the site. In parallel, the block decides whether a chain joins the left edge to the right edge. Conduction passes only between sites that share an edge.

A one-cycle start pulse captures the grid and a check-mode flag. Reach maps then grow one neighbour step per cycle until they stop changing or the iteration budget runs out. Then a one-cycle done pulse marks all results valid. In check mode, the left-to-right pass runs on the complement of the captured grid, and a flag reports when that result fails to be the inverse of the top-to-bottom result. A flagged assignment is one where the two functions are not duals, which happens when a diagonal-only contact blocks both directions.

Top module: `lattice_conn_eval`

## Requirements
- R1: The grid input bit at index r*COLS+c controls the site in row r (row 0 at the top) and column c (column 0 at the left). A value of 1 means the site conducts.
- R2: After done, tb_conn_o is 1 exactly when some chain of conducting sites, with each pair of consecutive sites sharing an edge, runs from a site in row 0 to a site in row ROWS-1.
- R3: Two conducting sites that touch only at a corner are not connected.
- R4: With check mode 0, lr_conn_o is 1 exactly when such a chain runs from column 0 to column COLS-1 of the captured grid. dual_err_o is then 0.
- R5: With check mode 1, lr_conn_o is the left-to-right result on the bitwise complement of the captured grid, and dual_err_o is 1 exactly when that result equals tb_conn_o.
- R6: For a 3x2 grid with site bits ordered x1,x4,x2,x5,x3,x6 from index 0 to 5, tb_conn_o equals x1x2x3 + x1x2x5x6 + x2x3x4x5 + x4x5x6.
- R7: done_o is a one-cycle pulse. It comes at most ROWS*COLS cycles after an accepted start. busy_o is high from the cycle after the start until done_o rises, and is low together with done_o.
- R8: A start pulse while busy_o is high is ignored. grid_i and check_en_i are sampled only when a start is accepted.
- R9: Reset (rst_ni low) clears busy_o, done_o, tb_conn_o, lr_conn_o and dual_err_o, and aborts a running evaluation.
- R10: The three result outputs change only in the cycle in which done_o is high, and hold otherwise.
- R11: dual_err_o is never 1 while tb_conn_o or lr_conn_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, captures grid and mode when idle |
| grid_i | input | ROWS*COLS | Site control bits, index r*COLS+c |
| check_en_i | input | 1 | Duality check mode |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | One-cycle pulse, results valid |
| tb_conn_o | output | 1 | Top-to-bottom connectivity |
| lr_conn_o | output | 1 | Left-to-right connectivity (on the complement in check mode) |
| dual_err_o | output | 1 | Duality violation in check mode |

## Verification
The bench builds two copies of the block. The first is a 3x2 lattice, small enough to drive all 64 assignments in both modes and compare them against the closed-form sum of products and a path-search model. The second is a 5x6 lattice driven with random grids. Its size allows snaking paths that need close to the full ROWS*COLS iteration budget, and diagonal-only blockages that raise the duality flag. Directed cases on the small lattice cover the ignored start, the grid changing mid-run, the result hold and the mid-run reset.

// File: rtl/lattice_pkg.sv
package lattice_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} lat_state_e;
  typedef enum logic {FLOW_TB, FLOW_LR} flow_dir_e;
endpackage

// File: rtl/lattice_flood.sv
module lattice_flood
  import lattice_pkg::*;
#(
  parameter int        ROWS = 3,
  parameter int        COLS = 2,
  parameter flow_dir_e DIR  = FLOW_TB
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 step_i,
  input  logic [ROWS*COLS-1:0] cond_i,
  output logic                 stable_o,
  output logic                 hit_o
);
  localparam int N = ROWS * COLS;

  logic [N-1:0] reach_q, reach_d, seed, far, nb;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int I  = r * COLS + c;
      localparam bit HN = (r > 0);
      localparam bit HS = (r < ROWS - 1);
      localparam bit HW = (c > 0);
      localparam bit HE = (c < COLS - 1);
      localparam int IN = HN ? I - COLS : I;
      localparam int IS = HS ? I + COLS : I;
      localparam int IW = HW ? I - 1 : I;
      localparam int IE = HE ? I + 1 : I;
      if (DIR == FLOW_TB) begin : g_tb
        assign seed[I] = (r == 0);
        assign far[I]  = (r == ROWS - 1);
      end else begin : g_lr
        assign seed[I] = (c == 0);
        assign far[I]  = (c == COLS - 1);
      end
      // edge neighbours only, no corner contact
      assign nb[I] = (HN & reach_q[IN]) | (HS & reach_q[IS]) |
                     (HW & reach_q[IW]) | (HE & reach_q[IE]);
    end
  end

  assign reach_d  = cond_i & (reach_q | seed | nb);
  assign stable_o = (reach_d == reach_q);
  assign hit_o    = |(reach_d & far);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      reach_q <= '0;
    else if (clear_i) reach_q <= '0;
    else if (step_i)  reach_q <= reach_d;
  end
endmodule

// File: rtl/lattice_ctrl.sv
module lattice_ctrl
  import lattice_pkg::*;
#(
  parameter int MAX_ITER = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stable_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic finish_o
);
  localparam int CW = $clog2(MAX_ITER + 1);

  lat_state_e    state_q;
  logic [CW-1:0] iter_q;

  assign busy_o   = (state_q == ST_RUN);
  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign step_o   = busy_o;
  assign finish_o = step_o && (stable_i || iter_q == CW'(MAX_ITER - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
    end else if (load_o) begin
      state_q <= ST_RUN;
      iter_q  <= '0;
    end else if (finish_o) begin
      state_q <= ST_IDLE;
    end else if (step_o) begin
      iter_q <= iter_q + 1'b1;
    end
  end
endmodule

// File: rtl/lattice_conn_eval.sv
module lattice_conn_eval
  import lattice_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [ROWS*COLS-1:0] grid_i,
  input  logic                 check_en_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 tb_conn_o,
  output logic                 lr_conn_o,
  output logic                 dual_err_o
);
  localparam int N = ROWS * COLS;

  logic [N-1:0] grid_q, lr_cond;
  logic chk_q, load, step, finish;
  logic tb_stable, lr_stable, tb_hit, lr_hit;

  lattice_ctrl #(.MAX_ITER(N)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .stable_i(tb_stable & lr_stable),
    .busy_o  (busy_o),
    .load_o  (load),
    .step_o  (step),
    .finish_o(finish)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grid_q <= '0;
      chk_q  <= 1'b0;
    end else if (load) begin
      grid_q <= grid_i;
      chk_q  <= check_en_i;
    end
  end

  assign lr_cond = grid_q ^ {N{chk_q}};

  lattice_flood #(.ROWS(ROWS), .COLS(COLS), .DIR(FLOW_TB)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(load), .step_i(step),
    .cond_i(grid_q), .stable_o(tb_stable), .hit_o(tb_hit)
  );

  lattice_flood #(.ROWS(ROWS), .COLS(COLS), .DIR(FLOW_LR)) u_lr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(load), .step_i(step),
    .cond_i(lr_cond), .stable_o(lr_stable), .hit_o(lr_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      tb_conn_o  <= 1'b0;
      lr_conn_o  <= 1'b0;
      dual_err_o <= 1'b0;
    end else begin
      done_o <= finish;
      if (finish) begin
        tb_conn_o  <= tb_hit;
        lr_conn_o  <= lr_hit;
        dual_err_o <= chk_q & (tb_hit == lr_hit);
      end
    end
  end
endmodule

// File: rtl/lattice_conn_eval_chk.sv
module lattice_conn_eval_chk #(
  parameter int ROWS = 3,
  parameter int COLS = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic tb_conn_o,
  input logic lr_conn_o,
  input logic dual_err_o
);
  localparam int N = ROWS * COLS;

  logic [31:0] busy_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= '0;
  end

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  a_r7_iter_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_cnt < N);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(tb_conn_o) && $stable(lr_conn_o) && $stable(dual_err_o));

  a_r11_planar: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dual_err_o |-> !tb_conn_o && !lr_conn_o);
endmodule

bind lattice_conn_eval lattice_conn_eval_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .tb_conn_o (tb_conn_o),
  .lr_conn_o (lr_conn_o),
  .dual_err_o(dual_err_o)
);

// File: tb/lattice_conn_eval_test.sv
module lattice_conn_eval_test;
  localparam int CLK_PERIOD = 10;
  localparam int AR = 3, AC = 2, AN = AR * AC;
  localparam int BR = 5, BC = 6, BN = BR * BC;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          start_a = 0, chk_a = 0;
  logic [AN-1:0] grid_a = '0;
  logic          busy_a, done_a, tb_a, lr_a, de_a;
  logic          start_b = 0, chk_b = 0;
  logic [BN-1:0] grid_b = '0;
  logic          busy_b, done_b, tb_b, lr_b, de_b;

  lattice_conn_eval #(.ROWS(AR), .COLS(AC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_a), .grid_i(grid_a),
    .check_en_i(chk_a), .busy_o(busy_a), .done_o(done_a),
    .tb_conn_o(tb_a), .lr_conn_o(lr_a), .dual_err_o(de_a));

  lattice_conn_eval #(.ROWS(BR), .COLS(BC)) uut_w (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_b), .grid_i(grid_b),
    .check_en_i(chk_b), .busy_o(busy_b), .done_o(done_b),
    .tb_conn_o(tb_b), .lr_conn_o(lr_b), .dual_err_o(de_b));

  int n_tests = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // independent path search: edge neighbours, seeds on the start edge
  function automatic bit path_model(input logic [63:0] g, input int rows,
                                    input int cols, input bit lr);
    logic [63:0] rch = '0;
    bit hit = 0;
    for (int it = 0; it <= rows * cols; it++)
      for (int r = 0; r < rows; r++)
        for (int c = 0; c < cols; c++) begin
          int i = r * cols + c;
          if (g[i] && !rch[i]) begin
            if ((lr ? c == 0 : r == 0) ||
                (r > 0 && rch[i - cols]) || (r < rows - 1 && rch[i + cols]) ||
                (c > 0 && rch[i - 1]) || (c < cols - 1 && rch[i + 1]))
              rch[i] = 1'b1;
          end
        end
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++)
        if (rch[r * cols + c] && (lr ? c == cols - 1 : r == rows - 1)) hit = 1;
    return hit;
  endfunction

  task automatic run_a(input logic [AN-1:0] g, input bit chk, output int cyc);
    @(negedge clk);
    grid_a = g; chk_a = chk; start_a = 1;
    @(negedge clk);
    start_a = 0; cyc = 1;
    while (!done_a && cyc < 200) begin @(negedge clk); cyc++; end
  endtask

  task automatic run_b(input logic [BN-1:0] g, input bit chk, output int cyc);
    @(negedge clk);
    grid_b = g; chk_b = chk; start_b = 1;
    @(negedge clk);
    start_b = 0; cyc = 1;
    while (!done_b && cyc < 200) begin @(negedge clk); cyc++; end
  endtask

  task automatic t_reset;
    check({busy_a, done_a, tb_a, lr_a, de_a} == 0, "R9", "reset outputs a",
          int'({busy_a, done_a, tb_a, lr_a, de_a}), 0);
    check({busy_b, done_b, tb_b, lr_b, de_b} == 0, "R9", "reset outputs b",
          int'({busy_b, done_b, tb_b, lr_b, de_b}), 0);
  endtask

  // R6 R2 R4 R5 R1: exhaustive 3x2
  task automatic t_example;
    for (int v = 0; v < 64; v++)
      for (int m = 0; m < 2; m++) begin
        logic [AN-1:0] g = AN'(v);
        bit x1 = g[0], x4 = g[1], x2 = g[2], x5 = g[3], x3 = g[4], x6 = g[5];
        bit f = (x1 & x2 & x3) | (x1 & x2 & x5 & x6) | (x2 & x3 & x4 & x5) | (x4 & x5 & x6);
        bit elr = path_model(64'(m ? ~g : g), AR, AC, 1);
        int cyc;
        run_a(g, bit'(m), cyc);
        check(tb_a == f, "R6", $sformatf("sop v=%0d", v), tb_a, f);
        check(tb_a == path_model(64'(g), AR, AC, 0), "R2", "tb model", tb_a, f);
        check(lr_a == elr, m ? "R5" : "R4", $sformatf("lr v=%0d", v), lr_a, elr);
        check(de_a == (m && (f == elr)), m ? "R5" : "R4", "dual flag", de_a,
              int'(m && (f == elr)));
        check(cyc <= AN, "R7", "latency", cyc, AN);
      end
  endtask

  // R3: diagonal contact only
  task automatic t_diagonal;
    int cyc;
    run_a(6'b01_10_01, 1'b0, cyc);   // r0c0, r1c1, r2c0
    check(tb_a == 0, "R3", "diag tb", tb_a, 0);
    run_a(6'b01_10_01, 1'b1, cyc);   // complement r0c1 r1c0 r2c1 also diagonal
    check(lr_a == 0, "R3", "diag lr comp", lr_a, 0);
    check(de_a == 1, "R5", "diag dual flag", de_a, 1);
  endtask

  // R8: start while busy and grid change mid-run ignored; R7 busy
  task automatic t_busy_ignore;
    int cyc = 1;
    @(negedge clk);
    grid_a = '1; chk_a = 0; start_a = 1;
    @(negedge clk);
    check(busy_a == 1, "R7", "busy after start", busy_a, 1);
    grid_a = '0; chk_a = 1;          // start held high: must be ignored
    @(negedge clk); cyc++;
    start_a = 0;
    while (!done_a && cyc < 200) begin @(negedge clk); cyc++; end
    check(tb_a == 1 && lr_a == 1 && de_a == 0, "R8", "ignored start",
          int'({tb_a, lr_a, de_a}), 6);
    check(busy_a == 0, "R7", "busy low at done", busy_a, 0);
    @(negedge clk);
    check(done_a == 0, "R7", "done one cycle", done_a, 0);
    check(busy_a == 0, "R8", "no restart", busy_a, 0);
  endtask

  // R10: outputs hold after done
  task automatic t_hold;
    int cyc;
    run_a(6'b11_11_11, 1'b0, cyc);
    grid_a = '0;
    repeat (3) @(negedge clk);
    check(tb_a == 1 && lr_a == 1, "R10", "hold", int'({tb_a, lr_a}), 3);
  endtask

  // R9: reset mid-run
  task automatic t_reset_mid;
    int cyc;
    @(negedge clk);
    grid_a = '1; chk_a = 0; start_a = 1;
    @(negedge clk);
    start_a = 0; rst_ni = 0;
    #1;
    check({busy_a, done_a, tb_a, lr_a, de_a} == 0, "R9", "mid-run reset",
          int'({busy_a, done_a, tb_a, lr_a, de_a}), 0);
    @(negedge clk); rst_ni = 1;
    repeat (2) @(negedge clk);
    check(busy_a == 0 && done_a == 0, "R9", "stays idle", int'({busy_a, done_a}), 0);
    run_a(6'b00_00_11, 1'b0, cyc);
    check(tb_a == 0 && lr_a == 1, "R9", "run after reset", int'({tb_a, lr_a}), 1);
  endtask

  // R2 R4 R5 R7 R11 on 5x6 random grids
  task automatic t_random;
    for (int k = 0; k < 300; k++) begin
      logic [BN-1:0] g = BN'({$urandom, $urandom});
      bit m = k[0];
      bit etb, elr;
      int cyc;
      if (k % 3 == 0) g = g | BN'({$urandom});
      etb = path_model(64'(g), BR, BC, 0);
      elr = path_model(64'(m ? ~g : g), BR, BC, 1);
      run_b(g, m, cyc);
      check(tb_b == etb, "R2", "rand tb", tb_b, etb);
      check(lr_b == elr, m ? "R5" : "R4", "rand lr", lr_b, elr);
      check(de_b == (m && etb == elr), "R5", "rand dual", de_b, int'(m && etb == elr));
      check(!(de_b && (tb_b || lr_b)), "R11", "planar", de_b, 0);
      check(cyc <= BN, "R7", "rand latency", cyc, BN);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1;
    @(negedge clk);
    t_example;
    t_diagonal;
    t_busy_ignore;
    t_hold;
    t_reset_mid;
    t_random;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule